// File: doc/BRIEF.md
# Dual Timebase Interrupt Generator

This block holds two free-running tick generators that divide the system clock down to low, selectable rates. Each generator has its own ladder of four power-of-two frequencies. The slow ladder runs at 8, 16, 32 or 64 Hz, and the fast ladder runs at 128, 256, 512 or 1024 Hz. With the default 27 MHz clock, one tick period lasts `CLK_HZ / frequency` clock cycles, with integer truncation.

Each tick sets a sticky flag in a 16-bit interrupt flag register. Software clears a flag by writing a one to its bit position. An enable register masks which flags drive the interrupt request. Flag bits above the two timer sources are reserved for other interrupt sources. These bits exist in the register but never become set here. Software reaches all three registers through a simple synchronous-write, combinational-read register bus.

Changing a generator's rate field restarts that generator's period count. The first tick at the new rate therefore comes one full new period after the write. The other generator keeps its phase.

Top module: `dual_timebase_irq`

## Requirements
- R1: While `rst_n` is low, the rate register, the enable register and the flag register all read zero, and `irq_o` is low.
- R2: The slow generator's rate field is bits [1:0] of the rate register (offset 0). With select s, it sets flag bit 0 every `CLK_HZ >> (3+s)` cycles. The first tick comes that many cycles after reset release or after a change of the field.
- R3: The fast generator's rate field is bits [3:2] of the rate register. With select s, it sets flag bit 1 every `CLK_HZ >> (7+s)` cycles, with the same restart timing as R2.
- R4: The rate register keeps only bits [3:0] of a write; bits [15:4] read as zero.
- R5: Flag bits 0 and 1 (offset 2) stay zero until their generator ticks, and then stay set until cleared.
- R6: A write to the flag register clears each flag written as one and leaves every flag written as zero unchanged. A write of all zeros changes nothing.
- R7: When a tick and a clearing write for the same flag land on the same cycle, the flag ends up set.
- R8: Flag bits [15:2] always read zero, even after a write of ones to them.
- R9: The enable register (offset 1) keeps the write data masked with 0x3FFB; other bits read zero.
- R10: `irq_o` is high exactly while some flag bit and the enable bit at the same position are both one.
- R11: A rate write that leaves a generator's field unchanged does not disturb that generator's phase. A changed field restarts only its own generator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of `CLK_HZ` hertz |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (2) | Register offset: 0 rate, 1 enable, 2 flags; 3 reads zero |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | DATA_W (16) | Combinational read data of the addressed register |
| irq_o | output | 1 | Interrupt request, level |

## Verification
A wrong internal state shows up in different ways depending on where it sits:
- **Count or period table:** the flag bit rises early or late. The bench catches this by reading the flag register one cycle before and in the cycle of each expected tick.
- **Missed or spurious restart:** this shifts a whole tick grid. The bench reads the flag at an instant where only the old grid would have ticked, and that read shows the error within one period.
- **Faulty flag or enable state:** this reaches `bus_rdata` and `irq_o` in the cycle after the write that caused it.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

   // register offsets on the bus
   localparam int unsigned RATE_OFS = 0;
   localparam int unsigned ENA_OFS  = 1;
   localparam int unsigned FLAG_OFS = 2;

   // width of one packed base-exponent entry in the timer parameter vector
   localparam int unsigned BASE_FLD_W = 8;

   // cycles per tick for a given clock, ladder base exponent and select
   function automatic int unsigned tick_period(input int unsigned clk_hz,
                                               input int unsigned base_log2,
                                               input int unsigned sel);
      return clk_hz >> (base_log2 + sel);
   endfunction

endpackage

// File: rtl/tbase_divider.sv
module tbase_divider
   import tbase_pkg::*;
#(
   parameter int unsigned CLK_HZ    = 27_000_000,
   parameter int unsigned BASE_LOG2 = 3,
   parameter int unsigned SEL_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             restart,
   output logic             tick
);

   localparam int unsigned N_RATES  = 1 << SEL_W;
   localparam int unsigned LONGEST  = tick_period(CLK_HZ, BASE_LOG2, 0);
   localparam int unsigned SHORTEST = tick_period(CLK_HZ, BASE_LOG2, N_RATES - 1);
   localparam int unsigned CNT_W    = (LONGEST > 2) ? $clog2(LONGEST) : 1;

   initial begin
      if (SHORTEST < 2)
         $error("tbase_divider: fastest rate needs at least two cycles per tick");
   end

   logic [CNT_W-1:0] limit_tbl [N_RATES];
   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] cnt_q;
   logic             wrap;

   // one terminal count per selectable rate, computed at elaboration
   generate
      for (genvar r = 0; r < N_RATES; r++) begin : g_lim
         localparam int unsigned PER = tick_period(CLK_HZ, BASE_LOG2, r);
         assign limit_tbl[r] = CNT_W'(PER - 1);
      end
   endgenerate

   assign limit = limit_tbl[sel];
   assign wrap  = (cnt_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (wrap)    cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end

   assign tick = wrap && !restart;

endmodule

// File: rtl/tbase_flags.sv
module tbase_flags #(
   parameter int unsigned         DATA_W    = 16,
   parameter int unsigned         SRC_N     = 2,
   parameter logic [DATA_W-1:0]   STAT_MASK = 16'h7FFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_en,
   input  logic [DATA_W-1:0] clr_mask,
   input  logic [SRC_N-1:0]  set_vec,
   input  logic [DATA_W-1:0] en_q,
   output logic [DATA_W-1:0] flag_q,
   output logic              irq
);

   initial begin
      if (SRC_N > DATA_W)
         $error("tbase_flags: more sources than flag bits");
   end

   logic [DATA_W-1:0] clr_bits;
   logic [DATA_W-1:0] set_bits;
   logic [DATA_W-1:0] flag_d;

   assign clr_bits = clr_en ? clr_mask : '0;
   assign set_bits = DATA_W'(set_vec);
   // a new tick beats a clear on the same cycle
   assign flag_d   = ((flag_q & ~clr_bits) | set_bits) & STAT_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag_d;
   end

   assign irq = |(flag_q & en_q);

endmodule

// File: rtl/tbase_regs.sv
module tbase_regs
   import tbase_pkg::*;
#(
   parameter int unsigned       DATA_W  = 16,
   parameter int unsigned       ADDR_W  = 2,
   parameter int unsigned       NUM_TB  = 2,
   parameter int unsigned       SEL_W   = 2,
   parameter logic [DATA_W-1:0] EN_MASK = 16'h3FFB
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   input  logic                     bus_we,
   input  logic [DATA_W-1:0]        flag_q,
   output logic [NUM_TB*SEL_W-1:0]  rate_q,
   output logic [DATA_W-1:0]        en_q,
   output logic [NUM_TB-1:0]        restart_vec,
   output logic                     flag_wr,
   output logic [DATA_W-1:0]        bus_rdata
);

   localparam int unsigned RATE_W = NUM_TB * SEL_W;

   initial begin
      if (RATE_W > DATA_W)
         $error("tbase_regs: rate fields do not fit the data width");
   end

   logic rate_hit, ena_hit, flag_hit;

   assign rate_hit = (bus_addr == ADDR_W'(RATE_OFS));
   assign ena_hit  = (bus_addr == ADDR_W'(ENA_OFS));
   assign flag_hit = (bus_addr == ADDR_W'(FLAG_OFS));
   assign flag_wr  = bus_we && flag_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q <= '0;
         en_q   <= '0;
      end else if (bus_we) begin
         if (rate_hit) rate_q <= bus_wdata[RATE_W-1:0];
         if (ena_hit)  en_q   <= bus_wdata & EN_MASK;
      end
   end

   // a generator restarts only when its own field takes a new value
   generate
      for (genvar t = 0; t < NUM_TB; t++) begin : g_rst
         assign restart_vec[t] = bus_we && rate_hit &&
            (bus_wdata[t*SEL_W +: SEL_W] != rate_q[t*SEL_W +: SEL_W]);
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (rate_hit)      bus_rdata = DATA_W'(rate_q);
      else if (ena_hit)  bus_rdata = en_q;
      else if (flag_hit) bus_rdata = flag_q;
   end

endmodule

// File: rtl/dual_timebase_irq.sv
module dual_timebase_irq
   import tbase_pkg::*;
#(
   parameter int unsigned                     CLK_HZ       = 27_000_000,
   parameter int unsigned                     DATA_W       = 16,
   parameter int unsigned                     ADDR_W       = 2,
   parameter int unsigned                     NUM_TB       = 2,
   parameter int unsigned                     SEL_W        = 2,
   parameter logic [NUM_TB*BASE_FLD_W-1:0]    TB_BASE_LOG2 = {8'd7, 8'd3},
   parameter logic [DATA_W-1:0]               STAT_MASK    = 16'h7FFF,
   parameter logic [DATA_W-1:0]               EN_MASK      = 16'h3FFB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);

   initial begin
      if (ADDR_W < 2)
         $error("dual_timebase_irq: three registers need at least two address bits");
   end

   logic [NUM_TB*SEL_W-1:0] rate_q;
   logic [DATA_W-1:0]       en_q;
   logic [DATA_W-1:0]       flag_q;
   logic [NUM_TB-1:0]       restart_vec;
   logic [NUM_TB-1:0]       tick_vec;
   logic                    flag_wr;

   tbase_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .NUM_TB (NUM_TB),
      .SEL_W  (SEL_W),
      .EN_MASK(EN_MASK)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_we     (bus_we),
      .flag_q     (flag_q),
      .rate_q     (rate_q),
      .en_q       (en_q),
      .restart_vec(restart_vec),
      .flag_wr    (flag_wr),
      .bus_rdata  (bus_rdata)
   );

   generate
      for (genvar t = 0; t < NUM_TB; t++) begin : g_tb
         tbase_divider #(
            .CLK_HZ   (CLK_HZ),
            .BASE_LOG2(int'(TB_BASE_LOG2[t*BASE_FLD_W +: BASE_FLD_W])),
            .SEL_W    (SEL_W)
         ) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (rate_q[t*SEL_W +: SEL_W]),
            .restart(restart_vec[t]),
            .tick   (tick_vec[t])
         );
      end
   endgenerate

   tbase_flags #(
      .DATA_W   (DATA_W),
      .SRC_N    (NUM_TB),
      .STAT_MASK(STAT_MASK)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_en  (flag_wr),
      .clr_mask(bus_wdata),
      .set_vec (tick_vec),
      .en_q    (en_q),
      .flag_q  (flag_q),
      .irq     (irq_o)
   );

endmodule

// File: rtl/tbase_chk.sv
module tbase_chk #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned NUM_TB   = 2,
   parameter int unsigned FLAG_ADR = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_we,
   input logic [NUM_TB-1:0] tick_vec,
   input logic [NUM_TB-1:0] restart_vec,
   input logic [DATA_W-1:0] flag_q,
   input logic              irq_o
);

   logic flag_write;
   assign flag_write = bus_we && (bus_addr == ADDR_W'(FLAG_ADR));

   generate
      for (genvar t = 0; t < NUM_TB; t++) begin : g_src
         // R5
         tick_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick_vec[t] |=> flag_q[t]);
         // R6
         clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_write && bus_wdata[t] && !tick_vec[t]) |=> !flag_q[t]);
         // R11
         restart_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            restart_vec[t] |=> !tick_vec[t]);
      end
   endgenerate

   // R6
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_write && (tick_vec == '0)) |=> $stable(flag_q));

   // R8
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[DATA_W-1:NUM_TB] == '0);

   // R10
   irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(|tick_vec) || $past(bus_we)));

   // R10
   irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(bus_we));

endmodule

bind dual_timebase_irq tbase_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .NUM_TB  (NUM_TB),
   .FLAG_ADR(tbase_pkg::FLAG_OFS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_we     (bus_we),
   .tick_vec   (tick_vec),
   .restart_vec(restart_vec),
   .flag_q     (flag_q),
   .irq_o      (irq_o)
);

// File: tb/dual_timebase_irq_tb.sv
`timescale 1ns/100ps
module dual_timebase_irq_tb;

   localparam int unsigned TB_CLK_HZ = 16384;
   localparam logic [1:0]  A_RATE = 2'd0;
   localparam logic [1:0]  A_ENA  = 2'd1;
   localparam logic [1:0]  A_FLAG = 2'd2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_rdata;
   logic        irq_o;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   typedef struct {
      logic [15:0] exp;
      bit          on_irq;
      string       req;
   } sb_item_t;

   sb_item_t sb_q [$];

   always #2.5 clk = ~clk;

   dual_timebase_irq #(.CLK_HZ(TB_CLK_HZ)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_we   (bus_we),
      .bus_rdata(bus_rdata),
      .irq_o    (irq_o)
   );

   // monitor: compares queued expectations away from the clock edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         sb_item_t it;
         logic [15:0] act;
         it  = sb_q.pop_front();
         act = it.on_irq ? {15'b0, irq_o} : bus_rdata;
         compared++;
         if (act !== it.exp) begin
            mismatched++;
            $display("FAIL %s: actual %04h expected %04h", it.req, act, it.exp);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk_rd(input logic [1:0] a, input logic [15:0] e, input string req);
      sb_item_t it;
      bus_addr = a;
      it.exp = e; it.on_irq = 1'b0; it.req = req;
      sb_q.push_back(it);
      @(negedge clk);
      #0.2;
   endtask

   task automatic chk_irq(input logic e, input string req);
      sb_item_t it;
      it.exp = {15'b0, e}; it.on_irq = 1'b1; it.req = req;
      sb_q.push_back(it);
      @(negedge clk);
      #0.2;
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(posedge clk);
      #1;
      bus_we    = 1'b0;
   endtask

   initial begin
      step(3);
      chk_rd(A_RATE, 16'h0000, "R1 rate in reset");
      chk_rd(A_ENA,  16'h0000, "R1 enable in reset");
      chk_rd(A_FLAG, 16'h0000, "R1 flags in reset");
      chk_irq(1'b0, "R1 irq in reset");
      rst_n = 1'b1;

      // default rates: slow period 2048, fast period 128
      step(127);  chk_rd(A_FLAG, 16'h0000, "R5 no flag before first tick");
      step(1);    chk_rd(A_FLAG, 16'h0002, "R3 fast tick at 128");
      step(1919); chk_rd(A_FLAG, 16'h0002, "R2 slow not yet at 2047");
      step(1);    chk_rd(A_FLAG, 16'h0003, "R2 slow tick at 2048");
      chk_irq(1'b0, "R10 irq masked");

      wr(A_ENA, 16'hFFFF);
      chk_rd(A_ENA, 16'h3FFB, "R9 enable mask");
      chk_irq(1'b1, "R10 irq enabled");

      wr(A_FLAG, 16'h0001); chk_rd(A_FLAG, 16'h0002, "R6 clear bit 0 only");
      wr(A_FLAG, 16'h0000); chk_rd(A_FLAG, 16'h0002, "R6 zero write ignored");
      wr(A_FLAG, 16'hFFFC); chk_rd(A_FLAG, 16'h0002, "R8 reserved stay zero");
      wr(A_FLAG, 16'h0002); chk_rd(A_FLAG, 16'h0000, "R6 clear bit 1");
      chk_irq(1'b0, "R10 irq after clear");

      // slow sel 1 (1024 cycles), fast sel 1 (64 cycles); write edge is W
      wr(A_RATE, 16'hFFF5);
      chk_rd(A_RATE, 16'h0005, "R4 rate register width");
      step(63);  chk_rd(A_FLAG, 16'h0000, "R11 restart fast");
      step(1);   chk_rd(A_FLAG, 16'h0002, "R3 fast sel1 period 64");
      step(959); chk_rd(A_FLAG, 16'h0002, "R2 slow sel1 not yet");
      step(1);   chk_rd(A_FLAG, 16'h0003, "R2 slow sel1 period 1024");

      wr(A_FLAG, 16'h0003); chk_rd(A_FLAG, 16'h0000, "R6 clear both");
      step(62);             chk_rd(A_FLAG, 16'h0000, "R6 stays clear");
      wr(A_FLAG, 16'h0002); chk_rd(A_FLAG, 16'h0002, "R7 tick beats clear");

      wr(A_FLAG, 16'h0002); chk_rd(A_FLAG, 16'h0000, "R6 clear fast flag");
      wr(A_RATE, 16'h0005);
      step(61); chk_rd(A_FLAG, 16'h0000, "R11 same value no restart");
      step(1);  chk_rd(A_FLAG, 16'h0002, "R11 phase kept at W+1152");

      wr(A_FLAG, 16'h0002);
      wr(A_RATE, 16'h0001);            // fast back to sel0, edge X = W+1154
      step(62);  chk_rd(A_FLAG, 16'h0000, "R11 old fast grid gone");
      step(65);  chk_rd(A_FLAG, 16'h0000, "R11 fast not yet at X+127");
      step(1);   chk_rd(A_FLAG, 16'h0002, "R11 fast restarted at X+128");
      step(765); chk_rd(A_FLAG, 16'h0002, "R11 slow untouched not yet");
      step(1);   chk_rd(A_FLAG, 16'h0003, "R11 slow kept phase W+2048");

      wr(A_ENA, 16'h0001);  chk_irq(1'b1, "R10 irq on bit 0");
      wr(A_FLAG, 16'h0001); chk_rd(A_FLAG, 16'h0002, "R6 clear slow flag");
      chk_irq(1'b0, "R10 bit 1 not enabled");

      // fastest: slow 256 cycles, fast 16 cycles; write edge is Y
      wr(A_RATE, 16'h000F); chk_rd(A_RATE, 16'h000F, "R4 max select");
      wr(A_FLAG, 16'h0003); chk_rd(A_FLAG, 16'h0000, "R6 clear before fast run");
      step(14);  chk_rd(A_FLAG, 16'h0000, "R3 fast sel3 not yet");
      step(1);   chk_rd(A_FLAG, 16'h0002, "R3 fast sel3 period 16");
      step(239); chk_rd(A_FLAG, 16'h0002, "R2 slow sel3 not yet");
      step(1);   chk_rd(A_FLAG, 16'h0003, "R2 slow sel3 period 256");
      chk_irq(1'b1, "R10 irq from slow flag");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule